// File: doc/BRIEF.md
# PCI Type-0 Configuration Header

This block holds the 64-byte configuration header of one PCI function and serves it through a simple register port. Each access presents a byte offset, an access width of 1, 2 or 4 bytes, and either a write with its data or a read. Read data, a read-valid pulse and an error pulse come back one cycle after the access. Parameters set the identity, class, interrupt and base-address reset values, and the window size of each of the six base address registers.

The block carries out the standard sizing exchange. Software writes all-ones to a base address register and reads back a mask that encodes the window size. The expansion ROM register has its own sizing pattern. Fields that are fixed for the function are protected. For each base address register the block presents the programmed base address and a flag that says the window has been mapped.

Top module: `pci_cfg_header`

## Requirements
- R1: After reset, every header field reads back its parameter value, every bit of `bar_mapped` is 0 and every `bar_base` word is 0. A second reset later in operation restores the same state.
- R2: A 4-byte write of 0xFFFFFFFF at a base address offset (0x10 + 4*i, i = 0..5) loads the address bits with ~(size-1). The protected low bits keep their stored value. Sizing never changes `bar_mapped` or `bar_base`.
- R3: Bit 0 of a stored base address value selects the space: 1 is I/O and 0 is memory. An I/O register keeps bits [1:0] against every write. A memory register keeps bits [3:0].
- R4: Any other 4-byte base address write stores the unprotected bits of the write data. If those bits are nonzero, `bar_mapped[i]` goes to 1 and `bar_base[i]` takes the address bits. Once set, the mapped flag stays set until reset, and a write with zero address bits leaves `bar_base` unchanged.
- R5: A 4-byte write of 0xFFFFFFFE at offset 0x30 (expansion ROM base) makes it read 0xFFFFFFFF. Any other 4-byte value written there is stored as written.
- R6: An access with a size other than 1, 2 or 4 raises `err`, changes no state and, when it is a read, returns zero data with `rd_valid` high.
- R7: Byte writes at 0x3C (interrupt line), 0x0C (cache line size) and 0x0D (latency timer) replace that one byte. The neighbouring bytes are unchanged.
- R8: Byte writes at 0x08 (revision), 0x0B (base class), 0x3D (interrupt pin), 0x3E (minimum grant) and 0x3F (maximum latency) are ignored without raising `err`.
- R9: A 2-byte write at 0x04 replaces the 16-bit command field. A 4-byte write at 0x04 replaces the command field with data bits [15:0] and leaves the status field at 0x06 unchanged. A 2-byte write at 0x06 is accepted without `err` and leaves status unchanged.
- R10: Any access at offset 0x40 or above raises `err`. A write there changes nothing, and a read there returns zero.
- R11: A write of a valid size to any offset not named writable in R2, R4, R5, R7, R8 or R9 raises `err` and leaves the header unchanged.
- R12: A read returns `size` bytes starting at the offset in little-endian order (lowest offset in bits [7:0]). Unused upper bytes and bytes past 0x3F read zero. `rd_valid`, `rd_data` and `err` appear in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_off | input | 8 | Byte offset into configuration space |
| acc_size | input | 3 | Access width in bytes (1, 2 or 4 valid) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 32 | Write data, little-endian from the offset |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |
| rd_valid | output | 1 | Read data valid |
| err | output | 1 | Access error, one cycle after the access |
| bar_base | output | 192 | Published base address per register, register i in bits [32*i+31:32*i] |
| bar_mapped | output | 6 | Window mapped flag per base address register |

## Verification
The assertions check several properties on every cycle. The read-valid pulse follows each read strobe and only a read strobe. An invalid size or an access past 0x3F always yields an error, and such reads return zero. Every base address register keeps its protected type bits, and its mapped flag never drops. A sizing write always leaves the size mask in the address bits, and a nonzero programming write publishes the written address. The ROM sizing pattern always reads back as all-ones. Other behaviours are shown only by the bench scenarios: little-endian byte placement at unaligned offsets, no spill between adjacent byte fields, writes that are ignored or refused, and the restore of every parameter value on a second reset.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    localparam int NUM_BARS  = 6;
    localparam int HDR_BYTES = 64;

    localparam logic [7:0] OFF_CMD   = 8'h04;
    localparam logic [7:0] OFF_STS   = 8'h06;
    localparam logic [7:0] OFF_REV   = 8'h08;
    localparam logic [7:0] OFF_BCLS  = 8'h0B;
    localparam logic [7:0] OFF_CLSZ  = 8'h0C;
    localparam logic [7:0] OFF_LTMR  = 8'h0D;
    localparam logic [7:0] OFF_BAR0  = 8'h10;
    localparam logic [7:0] OFF_ROM   = 8'h30;
    localparam logic [7:0] OFF_ILINE = 8'h3C;
    localparam logic [7:0] OFF_IPIN  = 8'h3D;
    localparam logic [7:0] OFF_MGNT  = 8'h3E;
    localparam logic [7:0] OFF_MLAT  = 8'h3F;

    localparam logic [31:0] ROM_SIZE_PAT = 32'hFFFF_FFFE;

    // Writable header fields plus the registered response
    typedef struct packed {
        logic [15:0] cmd;
        logic [7:0]  clsz;
        logic [7:0]  ltmr;
        logic [7:0]  iline;
        logic [31:0] rom;
        logic [31:0] rdat;
        logic        rvld;
        logic        err;
    } hdr_state_t;

    typedef struct packed {
        logic [31:0] value;
        logic [31:0] base;
        logic        mapped;
    } bar_state_t;

    function automatic logic size_ok(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

endpackage

// File: rtl/pcfg_bar_slot.sv
module pcfg_bar_slot
    import pcfg_pkg::*;
#(
    parameter logic [31:0] INIT_VAL = 32'h0,
    parameter logic [31:0] WIN_SIZE = 32'h10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hit,
    input  logic [31:0] wr_data,
    output logic [31:0] value,
    output logic [31:0] base,
    output logic        mapped
);

    localparam logic [31:0] SIZE_MASK = ~(WIN_SIZE - 32'd1);

    bar_state_t  st_d, st_q;
    logic [31:0] prot;

    always_comb begin
        st_d = st_q;
        prot = st_q.value[0] ? 32'h0000_0003 : 32'h0000_000F;
        if (wr_hit) begin
            if (wr_data == 32'hFFFF_FFFF) begin
                st_d.value = (SIZE_MASK & ~prot) | (st_q.value & prot);
            end else begin
                st_d.value = (wr_data & ~prot) | (st_q.value & prot);
                if ((wr_data & ~prot) != 32'h0) begin
                    st_d.mapped = 1'b1;
                    st_d.base   = wr_data & ~prot;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.value  <= INIT_VAL;
            st_q.base   <= 32'h0;
            st_q.mapped <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value  = st_q.value;
    assign base   = st_q.base;
    assign mapped = st_q.mapped;

    assert_io_bits_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> value[1:0] == $past(value[1:0]));

    assert_mem_bits_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !value[0] |=> value[3:0] == $past(value[3:0]));

    assert_sizing_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_data == 32'hFFFF_FFFF) |=> value[31:4] == SIZE_MASK[31:4]);

    assert_mapped_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mapped |=> mapped);

    assert_publish_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_data != 32'hFFFF_FFFF && wr_data[31:4] != 28'h0)
        |=> mapped && base[31:4] == $past(wr_data[31:4]));

endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header
    import pcfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
    parameter logic [15:0] CMD_INIT   = 16'h0000,
    parameter logic [15:0] STS_INIT   = 16'h0200,
    parameter logic [7:0]  REV_ID     = 8'h05,
    parameter logic [23:0] CLASS_CODE = 24'h020000,
    parameter logic [7:0]  CLSZ_INIT  = 8'h00,
    parameter logic [7:0]  LTMR_INIT  = 8'h00,
    parameter logic [7:0]  HDR_TYPE   = 8'h00,
    parameter logic [7:0]  BIST_INIT  = 8'h00,
    parameter logic [NUM_BARS*32-1:0] BAR_INIT =
        {32'h0, 32'h0, 32'h0, 32'h8, 32'h1, 32'h0},
    parameter logic [NUM_BARS*32-1:0] BAR_SIZE =
        {32'h10, 32'h10, 32'h10, 32'h10000, 32'h100, 32'h1000},
    parameter logic [31:0] CIS_PTR    = 32'h0,
    parameter logic [15:0] SUB_VID    = 16'h5E6F,
    parameter logic [15:0] SUB_ID     = 16'h7081,
    parameter logic [31:0] ROM_INIT   = 32'h0,
    parameter logic [7:0]  ILINE_INIT = 8'h0A,
    parameter logic [7:0]  IPIN_VAL   = 8'h01,
    parameter logic [7:0]  MGNT_VAL   = 8'h02,
    parameter logic [7:0]  MLAT_VAL   = 8'h08
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             acc_off,
    input  logic [2:0]             acc_size,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [31:0]            wr_data,
    output logic [31:0]            rd_data,
    output logic                   rd_valid,
    output logic                   err,
    output logic [NUM_BARS*32-1:0] bar_base,
    output logic [NUM_BARS-1:0]    bar_mapped
);

    localparam logic [8:0] HDR_LIMIT = 9'(HDR_BYTES);

    hdr_state_t    st_d, st_q;
    logic [31:0]   bar_val [NUM_BARS];
    logic [NUM_BARS-1:0] bar_hit;
    logic [7:0]    img [HDR_BYTES];
    logic          in_region;
    logic          wr_bad, rd_bad;
    logic [8:0]    idx;

    assign in_region = acc_off < 8'(HDR_BYTES);

    for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
        localparam logic [7:0] BAR_OFF = OFF_BAR0 + 8'(4 * i);
        assign bar_hit[i] = wr_en && (acc_size == 3'd4) && (acc_off == BAR_OFF);
        pcfg_bar_slot #(
            .INIT_VAL (BAR_INIT[i*32 +: 32]),
            .WIN_SIZE (BAR_SIZE[i*32 +: 32])
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (bar_hit[i]),
            .wr_data (wr_data),
            .value   (bar_val[i]),
            .base    (bar_base[i*32 +: 32]),
            .mapped  (bar_mapped[i])
        );
    end

    // Byte image of the header for reads
    always_comb begin
        for (int b = 0; b < HDR_BYTES; b++) img[b] = 8'h00;
        {img[1], img[0]}   = VENDOR_ID;
        {img[3], img[2]}   = DEVICE_ID;
        {img[5], img[4]}   = st_q.cmd;
        {img[7], img[6]}   = STS_INIT;
        img[8]             = REV_ID;
        {img[11], img[10], img[9]} = CLASS_CODE;
        img[12]            = st_q.clsz;
        img[13]            = st_q.ltmr;
        img[14]            = HDR_TYPE;
        img[15]            = BIST_INIT;
        for (int n = 0; n < NUM_BARS; n++) begin
            for (int k = 0; k < 4; k++) img[16 + 4*n + k] = bar_val[n][8*k +: 8];
        end
        {img[43], img[42], img[41], img[40]} = CIS_PTR;
        {img[45], img[44]} = SUB_VID;
        {img[47], img[46]} = SUB_ID;
        {img[51], img[50], img[49], img[48]} = st_q.rom;
        img[60]            = st_q.iline;
        img[61]            = IPIN_VAL;
        img[62]            = MGNT_VAL;
        img[63]            = MLAT_VAL;
    end

    always_comb begin
        st_d   = st_q;
        wr_bad = 1'b0;
        rd_bad = 1'b0;
        idx    = 9'h0;

        if (wr_en) begin
            if (!size_ok(acc_size) || !in_region) begin
                wr_bad = 1'b1;
            end else begin
                case (acc_size)
                    3'd1: begin
                        case (acc_off)
                            OFF_ILINE: st_d.iline = wr_data[7:0];
                            OFF_CLSZ:  st_d.clsz  = wr_data[7:0];
                            OFF_LTMR:  st_d.ltmr  = wr_data[7:0];
                            OFF_REV, OFF_BCLS, OFF_IPIN, OFF_MGNT, OFF_MLAT: ;
                            default:   wr_bad = 1'b1;
                        endcase
                    end
                    3'd2: begin
                        case (acc_off)
                            OFF_CMD: st_d.cmd = wr_data[15:0];
                            OFF_STS: ;
                            default: wr_bad = 1'b1;
                        endcase
                    end
                    default: begin
                        if (|bar_hit) begin
                            // handled inside the slot
                        end else if (acc_off == OFF_ROM) begin
                            st_d.rom = (wr_data == ROM_SIZE_PAT) ? 32'hFFFF_FFFF : wr_data;
                        end else if (acc_off == OFF_CMD) begin
                            st_d.cmd = wr_data[15:0];
                        end else begin
                            wr_bad = 1'b1;
                        end
                    end
                endcase
            end
        end

        st_d.rvld = rd_en;
        st_d.rdat = 32'h0;
        if (rd_en) begin
            if (!size_ok(acc_size) || !in_region) begin
                rd_bad = 1'b1;
            end else begin
                for (int i = 0; i < 4; i++) begin
                    idx = {1'b0, acc_off} + 9'(i);
                    if (idx < HDR_LIMIT && i < int'(acc_size))
                        st_d.rdat[8*i +: 8] = img[idx[5:0]];
                end
            end
        end
        st_d.err = wr_bad | rd_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmd   <= CMD_INIT;
            st_q.clsz  <= CLSZ_INIT;
            st_q.ltmr  <= LTMR_INIT;
            st_q.iline <= ILINE_INIT;
            st_q.rom   <= ROM_INIT;
            st_q.rdat  <= 32'h0;
            st_q.rvld  <= 1'b0;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.rdat;
    assign rd_valid = st_q.rvld;
    assign err      = st_q.err;

    assert_read_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_no_spurious_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_bad_size_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && !(acc_size == 3'd1 || acc_size == 3'd2 || acc_size == 3'd4))
        |=> err);

    assert_region_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && acc_off[7:6] != 2'b00) |=> (err && rd_data == 32'h0));

    assert_rom_sizing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_size == 3'd4 && acc_off == OFF_ROM && wr_data == ROM_SIZE_PAT)
        |=> st_q.rom == 32'hFFFF_FFFF);

    assert_refused_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_size == 3'd4 && acc_off == OFF_REV) |=> err);

endmodule

// File: tb/pci_cfg_header_bench.sv
module pci_cfg_header_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        is_rd;
        logic [31:0] data;
        logic        err;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   acc_off = 8'h0;
    logic [2:0]   acc_size = 3'd0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [31:0]  wr_data = 32'h0;
    logic [31:0]  rd_data;
    logic         rd_valid;
    logic         err;
    logic [191:0] bar_base;
    logic [5:0]   bar_mapped;

    int    n_checks = 0;
    int    n_fails  = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    pci_cfg_header u_pci_cfg_header (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_off    (acc_off),
        .acc_size   (acc_size),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .err        (err),
        .bar_base   (bar_base),
        .bar_mapped (bar_mapped)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compare each registered response against the scoreboard
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (rd_valid !== e.is_rd || err !== e.err || (e.is_rd && rd_data !== e.data)) begin
                n_fails++;
                $display("FAIL %s: rd_valid=%0b err=%0b rd_data=%h expected rd_valid=%0b err=%0b rd_data=%h",
                         t, rd_valid, err, rd_data, e.is_rd, e.err, e.data);
            end
        end
    end

    task automatic access(input logic is_wr, input logic [7:0] off, input logic [2:0] sz,
                          input logic [31:0] data, input logic [31:0] exp_data,
                          input logic exp_err, input string tag);
        exp_t e;
        acc_off  = off;
        acc_size = sz;
        wr_en    = is_wr;
        rd_en    = !is_wr;
        wr_data  = data;
        @(posedge clk);
        e.is_rd = !is_wr;
        e.data  = exp_data;
        e.err   = exp_err;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        #1;
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] off, input logic [2:0] sz, input logic [31:0] d,
                      input logic exp_err, input string tag);
        access(1'b1, off, sz, d, 32'h0, exp_err, tag);
    endtask

    task automatic rd(input logic [7:0] off, input logic [2:0] sz, input logic [31:0] exp_d,
                      input logic exp_err, input string tag);
        access(1'b0, off, sz, 32'h0, exp_d, exp_err, tag);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string tag);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk({26'h0, bar_mapped}, 32'h0, "R1 mapped after reset");
        chk(bar_base[31:0], 32'h0, "R1 base0 after reset");
        #1;
        rd(8'h00, 3'd4, 32'h3C4D1A2B, 1'b0, "R1 identity");
        rd(8'h08, 3'd4, 32'h02000005, 1'b0, "R1 class/revision");
        rd(8'h3C, 3'd4, 32'h0802010A, 1'b0, "R1 interrupt word");
        rd(8'h14, 3'd4, 32'h00000001, 1'b0, "R1 io bar init");
        rd(8'h2C, 3'd4, 32'h70815E6F, 1'b0, "R1 subsystem");

        // R12 little-endian, unaligned, past end
        rd(8'h01, 3'd2, 32'h00004D1A, 1'b0, "R12 unaligned half");
        rd(8'h3D, 3'd1, 32'h00000001, 1'b0, "R12 single byte");
        rd(8'h3E, 3'd4, 32'h00000802, 1'b0, "R12 bytes past end");

        // R7 byte writes without spill
        wr(8'h3C, 3'd1, 32'hFFFFFF55, 1'b0, "R7 iline write");
        rd(8'h3C, 3'd4, 32'h08020155, 1'b0, "R7 iline no spill");
        wr(8'h0C, 3'd1, 32'h00000040, 1'b0, "R7 cache line write");
        wr(8'h0D, 3'd1, 32'h00000020, 1'b0, "R7 latency write");
        rd(8'h0C, 3'd4, 32'h00002040, 1'b0, "R7 cache/latency no spill");

        // R8 ignored byte writes
        wr(8'h3D, 3'd1, 32'hFF, 1'b0, "R8 int pin ignored");
        wr(8'h3E, 3'd1, 32'hFF, 1'b0, "R8 min grant ignored");
        wr(8'h3F, 3'd1, 32'hFF, 1'b0, "R8 max latency ignored");
        wr(8'h08, 3'd1, 32'hFF, 1'b0, "R8 revision ignored");
        wr(8'h0B, 3'd1, 32'hFF, 1'b0, "R8 class ignored");
        rd(8'h3C, 3'd4, 32'h08020155, 1'b0, "R8 interrupt word unchanged");
        rd(8'h08, 3'd4, 32'h02000005, 1'b0, "R8 class word unchanged");

        // R9 command/status
        wr(8'h04, 3'd2, 32'h00000007, 1'b0, "R9 command half write");
        rd(8'h04, 3'd4, 32'h02000007, 1'b0, "R9 command readback");
        wr(8'h06, 3'd2, 32'h0000FFFF, 1'b0, "R9 status accepted");
        rd(8'h04, 3'd4, 32'h02000007, 1'b0, "R9 status unchanged");
        wr(8'h04, 3'd4, 32'hABCD0146, 1'b0, "R9 command word write");
        rd(8'h04, 3'd4, 32'h02000146, 1'b0, "R9 word write keeps status");

        // R11 refused writes
        wr(8'h00, 3'd1, 32'hFF, 1'b1, "R11 vendor byte");
        wr(8'h02, 3'd2, 32'hFFFF, 1'b1, "R11 device half");
        wr(8'h08, 3'd4, 32'hFFFFFFFF, 1'b1, "R11 class word");
        wr(8'h04, 3'd1, 32'hFF, 1'b1, "R11 command byte");
        wr(8'h11, 3'd4, 32'h12345678, 1'b1, "R11 unaligned bar");
        rd(8'h00, 3'd4, 32'h3C4D1A2B, 1'b0, "R11 identity unchanged");
        rd(8'h04, 3'd4, 32'h02000146, 1'b0, "R11 command unchanged");
        rd(8'h10, 3'd4, 32'h00000000, 1'b0, "R11 bar0 unchanged");

        // R6 invalid sizes
        wr(8'h3C, 3'd3, 32'hFFFFFFFF, 1'b1, "R6 size 3 write");
        rd(8'h3C, 3'd4, 32'h08020155, 1'b0, "R6 no effect");
        rd(8'h00, 3'd0, 32'h00000000, 1'b1, "R6 size 0 read");

        // R10 device-specific region
        wr(8'h40, 3'd4, 32'hFFFFFFFF, 1'b1, "R10 write beyond header");
        rd(8'h40, 3'd4, 32'h00000000, 1'b1, "R10 read beyond header");
        rd(8'h80, 3'd1, 32'h00000000, 1'b1, "R10 read high offset");

        // R2 sizing
        wr(8'h10, 3'd4, 32'hFFFFFFFF, 1'b0, "R2 size bar0");
        wr(8'h14, 3'd4, 32'hFFFFFFFF, 1'b0, "R2 size bar1");
        wr(8'h18, 3'd4, 32'hFFFFFFFF, 1'b0, "R2 size bar2");
        rd(8'h10, 3'd4, 32'hFFFFF000, 1'b0, "R2 bar0 mask");
        rd(8'h14, 3'd4, 32'hFFFFFF01, 1'b0, "R2 bar1 io mask");
        rd(8'h18, 3'd4, 32'hFFFF0008, 1'b0, "R2 bar2 prefetch mask");
        @(negedge clk);
        chk({26'h0, bar_mapped}, 32'h0, "R2 sizing does not map");
        #1;

        // R3/R4 programming
        wr(8'h10, 3'd4, 32'h8000000F, 1'b0, "R3 bar0 program");
        wr(8'h14, 3'd4, 32'h0000C002, 1'b0, "R3 bar1 program");
        wr(8'h18, 3'd4, 32'h00000007, 1'b0, "R4 bar2 zero address");
        rd(8'h10, 3'd4, 32'h80000000, 1'b0, "R3 memory low bits kept");
        rd(8'h14, 3'd4, 32'h0000C001, 1'b0, "R3 io low bits kept");
        rd(8'h18, 3'd4, 32'h00000008, 1'b0, "R4 bar2 value");
        @(negedge clk);
        chk({26'h0, bar_mapped}, 32'h00000003, "R4 mapped flags");
        chk(bar_base[31:0], 32'h80000000, "R4 bar0 base");
        chk(bar_base[63:32], 32'h0000C000, "R4 bar1 base");
        chk(bar_base[95:64], 32'h0, "R4 bar2 base");
        #1;
        wr(8'h10, 3'd4, 32'h00000000, 1'b0, "R4 bar0 cleared");
        wr(8'h14, 3'd4, 32'hFFFFFFFF, 1'b0, "R2 resize bar1");
        @(negedge clk);
        chk({26'h0, bar_mapped}, 32'h00000003, "R4 mapped sticky");
        chk(bar_base[31:0], 32'h80000000, "R4 base held on zero write");
        chk(bar_base[63:32], 32'h0000C000, "R2 base held on sizing");
        #1;

        // R5 expansion ROM
        wr(8'h30, 3'd4, 32'hFFFFFFFE, 1'b0, "R5 rom sizing");
        rd(8'h30, 3'd4, 32'hFFFFFFFF, 1'b0, "R5 rom size readback");
        wr(8'h30, 3'd4, 32'h12340001, 1'b0, "R5 rom program");
        rd(8'h30, 3'd4, 32'h12340001, 1'b0, "R5 rom stored as written");

        // R1 reset restores everything
        @(negedge clk);
        do_reset();
        @(negedge clk);
        chk({26'h0, bar_mapped}, 32'h0, "R1 mapped cleared by reset");
        chk(bar_base[31:0], 32'h0, "R1 base cleared by reset");
        #1;
        rd(8'h3C, 3'd4, 32'h0802010A, 1'b0, "R1 iline restored");
        rd(8'h04, 3'd4, 32'h02000000, 1'b0, "R1 command restored");
        rd(8'h0C, 3'd2, 32'h00000000, 1'b0, "R1 cache/latency restored");
        rd(8'h14, 3'd4, 32'h00000001, 1'b0, "R1 bar1 restored");
        rd(8'h30, 3'd4, 32'h00000000, 1'b0, "R1 rom restored");

        repeat (3) @(posedge clk);
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule